// File: doc/BRIEF.md
# Sine-Table Duty Cycle Sequencer

This block drives the two bridge legs of a four-phase PWM timer with duty values that follow a sine. Each time the timer signals the end of its PWM cycle, the sequencer hands over the next table sample. The sample goes out as the on-time for leg A, and its 8-bit complement goes out as the on-time for leg B. In the clock after that it raises a one-cycle commit strobe, so the timer takes both values in at its next cycle end. The PWM rate stays fixed. The output frequency is set only by how many samples one sine period walks through: 386 for the 50 Hz setting and 322 for the 60 Hz setting. The samples are computed when the design is elaborated from a rational sine approximation that is symmetric about the quarter points, so no table file is needed.

The control is a two-state machine:
- **ST_IDLE** waits for a pulse.
- **ST_FETCH** spends one clock reading the next sample into a prefetch register, so the sample is ready long before the following cycle end.

The machine has three named transitions:
- **T_ADVANCE**: ST_IDLE to ST_FETCH on an accepted pulse. The pointer steps forward and wraps to zero at the table length.
- **T_CLAMP**: ST_IDLE to ST_FETCH when the frequency select has moved the wrap point to or below the pointer. The pointer is forced to zero.
- **T_DONE**: ST_FETCH to ST_IDLE, always.

The select input may change at any time while the block runs.

Top module: `sine_duty_seq`

## Requirements
- R1: While reset is asserted and until the first accepted pulse, duty A is 127, duty B is 128 and commit is low. The first pulse after reset hands out sample 0, which is 127.
- R2: For a table of N samples with h = N/2, sample 0 and sample h are 127. Samples N/4 (rounded down) and N/4+1 are 255. Samples h+N/4 and h+N/4+1 are 0. For every i below h, sample i plus sample i+h lies in 254..255.
- R3: Duty B always equals 255 minus duty A.
- R4: Commit is high for exactly the one clock that follows the clock edge at which a pulse is accepted. At all other times it is low.
- R5: Duty A and duty B change only at the clock edge that accepts a pulse.
- R6: With select low, the handed-out sequence repeats every 386 accepted pulses.
- R7: With select high, the handed-out sequence repeats every 322 accepted pulses.
- R8: If select changes so that the pointer is at or beyond the new length, the pointer goes to zero one clock later. The next pulse, given at least three clocks after the change, hands out 127, and the pulse after that hands out sample 1 of the new table.
- R9: If select changes while the pointer is below the new length, the next pulse hands out the sample already prefetched from the old table. Later pulses continue from the following index in the new table.
- R10: A pulse in the clock right after an accepted pulse or a clamp is ignored: it causes no commit, no output change and no pointer step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_end_i | input | 1 | One-clock end-of-PWM-cycle pulse from the timer |
| freq_sel_i | input | 1 | Table length select: 0 gives 386 samples (50 Hz), 1 gives 322 samples (60 Hz) |
| duty_a_o | output | 8 | On-time compare value for leg A |
| duty_b_o | output | 8 | On-time compare value for leg B, the complement of A |
| commit_o | output | 1 | One-clock request to load both compare values at the next cycle end |

## Verification
Duty A, duty B and commit are all due one clock after an accepted pulse. The prefetched sample is in place two clocks after it, and a clamp takes effect one clock after the select changes. The bench drives each pulse high for one clock from a falling edge and reads the outputs at the next falling edge, where commit must be high. It checks that commit has dropped one falling edge later and then waits one more clock, so every pulse lands in ST_IDLE with its sample ready. The select is changed three clocks before the next pulse. The ignore case holds the pulse high for a second clock on purpose and reads commit and duty A at the falling edge after that second clock.

// File: rtl/sds_pkg.sv
package sds_pkg;
    localparam int DUTY_W = 8;
    typedef logic [DUTY_W-1:0] duty_t;
    localparam int   FULL  = (1 << DUTY_W) - 1;
    localparam duty_t MID  = duty_t'(FULL / 2);

    typedef enum logic [0:0] {ST_IDLE, ST_FETCH} seq_state_e;

    // Rational sine approximation over each half period, scaled so the
    // positive half peaks at FULL and the negative half bottoms at 0.
    function automatic duty_t sine_sample(input int idx, input int len);
        longint half, p, q, num, den, mag;
        bit     neg;
        half = len / 2;
        if (idx < half) begin
            p   = idx;
            neg = 1'b0;
        end else begin
            p   = idx - half;
            neg = 1'b1;
        end
        q   = p * (half - p);
        num = 16 * q;
        den = 5 * half * half - 4 * q;
        if (den == 0) den = 1;
        if (!neg) begin
            mag = (((FULL + 1) / 2) * num + den / 2) / den;
            return duty_t'(FULL / 2 + mag);
        end else begin
            mag = ((FULL / 2) * num + den / 2) / den;
            return duty_t'(FULL / 2 - mag);
        end
    endfunction
endpackage

// File: rtl/sds_sine_rom.sv
module sds_sine_rom
    import sds_pkg::*;
#(
    parameter int LEN50 = 386,
    parameter int LEN60 = 322,
    parameter int IW    = 9
) (
    input  logic [IW-1:0] idx,
    input  logic          sel,
    output duty_t         data
);
    duty_t t50 [LEN50];
    duty_t t60 [LEN60];

    for (genvar i = 0; i < LEN50; i++) begin : g_t50
        assign t50[i] = sine_sample(i, LEN50);
    end
    for (genvar j = 0; j < LEN60; j++) begin : g_t60
        assign t60[j] = sine_sample(j, LEN60);
    end

    always_comb begin
        data = MID;
        if (sel) begin
            if (int'(idx) < LEN60) data = t60[idx];
        end else begin
            if (int'(idx) < LEN50) data = t50[idx];
        end
    end
endmodule

// File: rtl/sds_ptr_ctrl.sv
module sds_ptr_ctrl
    import sds_pkg::*;
#(
    parameter int LEN50 = 386,
    parameter int LEN60 = 322,
    parameter int IW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_end,
    input  logic          sel,
    output logic [IW-1:0] ptr,
    output logic          accept,
    output logic          fetch_en
);
    seq_state_e    state, state_n;
    logic [IW-1:0] ptr_n;
    logic [IW-1:0] wrap;
    logic [IW-1:0] ptr_inc;

    assign wrap    = sel ? IW'(LEN60) : IW'(LEN50);
    assign ptr_inc = ptr + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr   <= '0;
        end else begin
            state <= state_n;
            ptr   <= ptr_n;
        end
    end

    always_comb begin
        state_n = state;
        ptr_n   = ptr;
        accept  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cyc_end) begin                // T_ADVANCE
                    accept  = 1'b1;
                    ptr_n   = (ptr_inc >= wrap) ? '0 : ptr_inc;
                    state_n = ST_FETCH;
                end else if (ptr >= wrap) begin   // T_CLAMP
                    ptr_n   = '0;
                    state_n = ST_FETCH;
                end
            end
            ST_FETCH: begin                       // T_DONE
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign fetch_en = (state == ST_FETCH);
endmodule

// File: rtl/sine_duty_seq.sv
module sine_duty_seq
    import sds_pkg::*;
#(
    parameter int LEN50 = 386,
    parameter int LEN60 = 322
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_end_i,
    input  logic              freq_sel_i,
    output logic [DUTY_W-1:0] duty_a_o,
    output logic [DUTY_W-1:0] duty_b_o,
    output logic              commit_o
);
    localparam int LEN_MAX = (LEN50 > LEN60) ? LEN50 : LEN60;
    localparam int IW      = $clog2(LEN_MAX + 1);

    logic [IW-1:0] ptr;
    logic          accept;
    logic          fetch_en;
    duty_t         rom_data;
    duty_t         next_val;

    sds_ptr_ctrl #(.LEN50(LEN50), .LEN60(LEN60), .IW(IW)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_end  (cyc_end_i),
        .sel      (freq_sel_i),
        .ptr      (ptr),
        .accept   (accept),
        .fetch_en (fetch_en)
    );

    sds_sine_rom #(.LEN50(LEN50), .LEN60(LEN60), .IW(IW)) rom_i (
        .idx  (ptr),
        .sel  (freq_sel_i),
        .data (rom_data)
    );

    // Output and prefetch registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_val <= MID;
            duty_a_o <= MID;
            duty_b_o <= ~MID;
            commit_o <= 1'b0;
        end else begin
            if (fetch_en) next_val <= rom_data;
            if (accept) begin
                duty_a_o <= next_val;
                duty_b_o <= ~next_val;
            end
            commit_o <= accept;
        end
    end
endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
    parameter int LEN_MAX = 386,
    parameter int IW      = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          accept,
    input logic [IW-1:0] ptr,
    input logic [7:0]    duty_a_o,
    input logic [7:0]    duty_b_o,
    input logic          commit_o
);
    // R3
    sum_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, duty_a_o} + {1'b0, duty_b_o}) == 9'd255);

    // R4
    commit_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> commit_o);

    // R4
    commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !commit_o);

    // R5
    hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(duty_a_o));

    // R5
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(duty_b_o));

    // R6
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < LEN_MAX);
endmodule

bind sine_duty_seq sds_checker #(.LEN_MAX(LEN_MAX), .IW(IW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .ptr      (ptr),
    .duty_a_o (duty_a_o),
    .duty_b_o (duty_b_o),
    .commit_o (commit_o)
);

// File: tb/sine_duty_seq_tb.sv
`timescale 1ns/1ps
module sine_duty_seq_tb_top;
    localparam int N50 = 386;
    localparam int N60 = 322;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_end = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] a, b;
    logic       commit;

    int checks = 0;
    int errors = 0;
    int s50 [N50 + 2];
    int s60 [N60 + 2];

    always #5 clk = ~clk;

    sine_duty_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_end_i  (cyc_end),
        .freq_sel_i (sel),
        .duty_a_o   (a),
        .duty_b_o   (b),
        .commit_o   (commit)
    );

    // selector, table index, low bound, high bound  (R2)
    localparam int VEC [10][4] = '{
        '{0, 0,   127, 127}, '{0, 193, 127, 127},
        '{0, 96,  255, 255}, '{0, 97,  255, 255},
        '{0, 289, 0,   0  }, '{0, 290, 0,   0  },
        '{1, 0,   127, 127}, '{1, 161, 127, 127},
        '{1, 80,  255, 255}, '{1, 242, 0,   0  }
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc_end = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(output int val);
        cyc_end = 1'b1;
        @(negedge clk);
        cyc_end = 1'b0;
        check(commit == 1'b1, "R4", int'(commit), 1);
        check(int'(a) + int'(b) == 255, "R3", int'(a) + int'(b), 255);
        val = int'(a);
        @(negedge clk);
        check(commit == 1'b0, "R4", int'(commit), 0);
        @(negedge clk);
    endtask

    initial begin
        int v, hold_a;
        int bad;
        @(negedge clk);
        // R1 reset state
        check(a == 8'd127, "R1", int'(a), 127);
        check(b == 8'd128, "R1", int'(b), 128);
        check(commit == 1'b0, "R1", int'(commit), 0);
        do_reset();
        @(negedge clk);
        check(a == 8'd127 && commit == 1'b0, "R1", int'(a), 127);

        // Collect the 50 Hz walk
        sel = 1'b0;
        for (int i = 0; i < N50 + 2; i++) begin
            pulse(v);
            s50[i] = v;
        end
        check(s50[0] == 127, "R1", s50[0], 127);
        check(s50[N50] == s50[0] && s50[N50 + 1] == s50[1], "R6", s50[N50 + 1], s50[1]);

        // Collect the 60 Hz walk
        do_reset();
        sel = 1'b1;
        @(negedge clk);
        for (int i = 0; i < N60 + 2; i++) begin
            pulse(v);
            s60[i] = v;
        end
        check(s60[N60] == s60[0] && s60[N60 + 1] == s60[1], "R7", s60[N60 + 1], s60[1]);
        check(s60[N60 - 1] != s60[0] || s60[1] != s60[N60 - 1], "R7", s60[N60 - 1], -1);

        // R2 shape checkpoints
        for (int k = 0; k < 10; k++) begin
            v = (VEC[k][0] != 0) ? s60[VEC[k][1]] : s50[VEC[k][1]];
            check(v >= VEC[k][2] && v <= VEC[k][3], "R2", v, VEC[k][2]);
        end
        bad = 0;
        for (int i = 0; i < N50 / 2; i++)
            if (s50[i] + s50[i + N50 / 2] < 254 || s50[i] + s50[i + N50 / 2] > 255) bad++;
        for (int i = 0; i < N60 / 2; i++)
            if (s60[i] + s60[i + N60 / 2] < 254 || s60[i] + s60[i + N60 / 2] > 255) bad++;
        check(bad == 0, "R2", bad, 0);

        // R8 clamp when the pointer lies beyond the new length
        do_reset();
        sel = 1'b0;
        for (int i = 0; i < 350; i++) pulse(v);
        sel = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        pulse(v);
        check(v == 127, "R8", v, 127);
        pulse(v);
        check(v == s60[1], "R8", v, s60[1]);

        // R9 switch below the new length keeps the index
        do_reset();
        sel = 1'b1;
        for (int i = 0; i < 100; i++) pulse(v);
        sel = 1'b0;
        @(negedge clk);
        @(negedge clk);
        pulse(v);
        check(v == s60[100], "R9", v, s60[100]);
        pulse(v);
        check(v == s50[101], "R9", v, s50[101]);

        // R10 pulse in the clock after an accepted pulse is ignored
        do_reset();
        sel = 1'b0;
        cyc_end = 1'b1;
        @(negedge clk);
        hold_a = int'(a);
        @(negedge clk);
        cyc_end = 1'b0;
        check(commit == 1'b0, "R10", int'(commit), 0);
        check(int'(a) == hold_a, "R10", int'(a), hold_a);
        @(negedge clk);
        check(int'(a) == hold_a && commit == 1'b0, "R5", int'(a), hold_a);
        pulse(v);
        check(v == s50[1], "R10", v, s50[1]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule